// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Interrupt Flags

This block is a two-port byte memory, 1024 x 8 by default, with a left port and a right port. Each port has its own enable, output enable, write strobe, address, write data and read data, and each can reach every location. The ports run on one clock. A read returns data one cycle after it is sampled, and the read data register holds its value between reads. Address arbitration is not done here. Each port instead receives an active-low busy input from outside. While a port's busy input is low, that port's writes do not change the memory and its accesses do not change any flag.

The two highest addresses also serve as mailboxes for signalling from one port to the other. The left port owns address top-1 (0x3FE) and the right port owns the top address (0x3FF). When one port writes the other port's mailbox, the owner's interrupt flag is raised. The owner clears its flag by accessing its own mailbox with both enable and output enable asserted.

Each flag is a registered, active-low output and is always driven. Both mailbox bytes remain ordinary storage. Software decides what the message byte means.

Top module: `mbx_dual_port_top`

## Requirements
- R1: During and right after reset, both interrupt outputs are high (inactive) and both read data outputs are zero.
- R2: A write on either port (enable low, write strobe low, busy high) stores its byte. A read on either port (enable low, output enable low, write strobe high) shows that location's byte on that port's read data one clock later. Either port sees what the other port wrote.
- R3: A right-port write to address 0x3FE with busy high drives the left interrupt output low one clock after the write is sampled.
- R4: A left-port access to 0x3FE with enable and output enable low and busy high drives the left interrupt output high one clock later. The level of the write strobe does not matter.
- R5: A left-port write to address 0x3FF with busy high drives the right interrupt output low one clock later.
- R6: A right-port access to 0x3FF with enable and output enable low and busy high drives the right interrupt output high one clock later.
- R7: A set or clear access makes no change to any flag while the accessing port's busy input is low.
- R8: A write by a port whose busy input is low leaves the memory unchanged.
- R9: If a flag is set and cleared in the same cycle, the flag ends up low (set wins).
- R10: Addresses 0x3FE and 0x3FF store and return bytes like every other location.
- R11: No other access changes a flag. This covers a port writing its own mailbox, a mailbox access with output enable high and no write from the peer, the peer reading a mailbox, and access to any other address.
- R12: In a cycle with no read on a port, that port's read data output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_busy_n | input | 1 | Left busy from external arbitration, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_int_n | output | 1 | Left interrupt flag, active low |
| r_ce_n | input | 1 | Right enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_busy_n | input | 1 | Right busy from external arbitration, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_int_n | output | 1 | Right interrupt flag, active low |

## Verification
Each flag register is one bit of state, and a wrong update shows on its interrupt pin on the clock edge that samples the access. The checks therefore look exactly one cycle after every set, clear and blocked access. Every pairing of set, clear and the two busy inputs is tried from both starting flag levels, so a wrong priority or a missing busy gate appears at once as a wrong level. A bad decode or a lost write in the memory appears at the read data output one cycle after a read. A full write-then-read pass over every address, from both ports, exposes it on the first location affected.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Decoded intent of one port in one cycle
  typedef struct packed {
    logic wr;        // write that reaches the array
    logic rd;        // read that loads the read data register
    logic set_peer;  // write to the peer's mailbox
    logic clr_own;   // qualifying access to own mailbox
  } acc_t;

  localparam int unsigned SIDES = 2;
  localparam int unsigned LEFT  = 0;
  localparam int unsigned RIGHT = 1;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned OWN_OFS  = 1,   // own mailbox = top - OWN_OFS
  parameter int unsigned PEER_OFS = 0    // peer mailbox = top - PEER_OFS
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  localparam logic [ADDR_W-1:0] TOP      = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] OWN_MBX  = TOP - ADDR_W'(OWN_OFS);
  localparam logic [ADDR_W-1:0] PEER_MBX = TOP - ADDR_W'(PEER_OFS);

  logic sel, granted, hit_own, hit_peer;

  always_comb begin
    sel      = ~ce_n;
    granted  = sel & busy_n;
    hit_own  = (addr == OWN_MBX);
    hit_peer = (addr == PEER_MBX);
    acc.wr       = granted & ~we_n;
    acc.rd       = sel & ~oe_n & we_n;
    acc.set_peer = granted & ~we_n & hit_peer;
    acc.clr_own  = granted & ~oe_n & hit_own;
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_n
);
  always_ff @(posedge clk) begin
    if (rst)        flag_n <= 1'b1;
    else if (set_i) flag_n <= 1'b0;   // set wins: no message is dropped
    else if (clr_i) flag_n <= 1'b1;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> !flag_n);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> flag_n);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(flag_n));

endmodule

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned NRD   = 2;

  logic [DATA_W-1:0] mem [DEPTH];

  // one process owns the array; port b lands last on a shared address
  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  logic              rd_en   [NRD];
  logic [ADDR_W-1:0] rd_addr [NRD];
  logic [DATA_W-1:0] rd_q    [NRD];

  assign rd_en[0]   = a_rd;
  assign rd_en[1]   = b_rd;
  assign rd_addr[0] = a_addr;
  assign rd_addr[1] = b_addr;

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)            rd_q[g] <= '0;
      else if (rd_en[g])  rd_q[g] <= mem[rd_addr[g]];
    end

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
      !rd_en[g] |=> $stable(rd_q[g]));
  end

  assign a_rdata = rd_q[0];
  assign b_rdata = rd_q[1];

endmodule

// File: rtl/mbx_dual_port_top.sv
module mbx_dual_port_top
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce_n,
  input  logic              l_oe_n,
  input  logic              l_we_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_int_n,
  input  logic              r_ce_n,
  input  logic              r_oe_n,
  input  logic              r_we_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_int_n
);
  localparam logic [ADDR_W-1:0] TOP   = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] L_MBX = TOP - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] R_MBX = TOP;

  acc_t acc [SIDES];
  logic flag_n [SIDES];

  mbx_port_decode #(.ADDR_W(ADDR_W), .OWN_OFS(1), .PEER_OFS(0)) u_dec_l (
    .ce_n(l_ce_n), .oe_n(l_oe_n), .we_n(l_we_n), .busy_n(l_busy_n),
    .addr(l_addr), .acc(acc[LEFT])
  );

  mbx_port_decode #(.ADDR_W(ADDR_W), .OWN_OFS(0), .PEER_OFS(1)) u_dec_r (
    .ce_n(r_ce_n), .oe_n(r_oe_n), .we_n(r_we_n), .busy_n(r_busy_n),
    .addr(r_addr), .acc(acc[RIGHT])
  );

  // flag of side s is set by the other side, cleared by its own side
  for (genvar s = 0; s < SIDES; s++) begin : g_flag
    mbx_flag u_flag (
      .clk(clk), .rst(rst),
      .set_i(acc[SIDES-1-s].set_peer),
      .clr_i(acc[s].clr_own),
      .flag_n(flag_n[s])
    );
  end

  assign l_int_n = flag_n[LEFT];
  assign r_int_n = flag_n[RIGHT];

  mbx_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst),
    .a_wr(acc[LEFT].wr),  .a_rd(acc[LEFT].rd),  .a_addr(l_addr),
    .a_wdata(l_wdata), .a_rdata(l_rdata),
    .b_wr(acc[RIGHT].wr), .b_rd(acc[RIGHT].rd), .b_addr(r_addr),
    .b_wdata(r_wdata), .b_rdata(r_rdata)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (l_int_n && r_int_n));
  p_lset_src_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(l_int_n) |-> $past(!r_ce_n && !r_we_n && r_busy_n && r_addr == L_MBX));
  p_rset_src_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(r_int_n) |-> $past(!l_ce_n && !l_we_n && l_busy_n && l_addr == R_MBX));
  p_lclr_src_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(l_int_n) |-> $past(!l_ce_n && !l_oe_n && l_busy_n && l_addr == L_MBX));
  p_rclr_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(r_int_n) |-> $past(!r_ce_n && !r_oe_n && r_busy_n && r_addr == R_MBX));
  p_lbusy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_n && r_ce_n) |=> $stable(l_int_n));
  p_rbusy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (!r_busy_n && l_ce_n) |=> $stable(r_int_n));

endmodule

// File: tb/mbx_dual_port_top_tb_top.sv
`timescale 1ns/1ps
module mbx_dual_port_top_tb_top;
  localparam int AW  = 10;
  localparam int DW  = 8;
  localparam int TOPA = (1 << AW) - 1;
  localparam logic [AW-1:0] LM = AW'(TOPA - 1);
  localparam logic [AW-1:0] RM = AW'(TOPA);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_ce_n, l_oe_n, l_we_n, l_busy_n;
  logic r_ce_n, r_oe_n, r_we_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_int_n, r_int_n;
  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_dual_port_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst),
    .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
    .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n)
  );

  function automatic logic [DW-1:0] dat(input int a);
    return DW'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic l_drv(input logic ce, oe, we, input int a, input int d);
    l_ce_n = ce; l_oe_n = oe; l_we_n = we; l_addr = AW'(a); l_wdata = DW'(d);
  endtask

  task automatic r_drv(input logic ce, oe, we, input int a, input int d);
    r_ce_n = ce; r_oe_n = oe; r_we_n = we; r_addr = AW'(a); r_wdata = DW'(d);
  endtask

  task automatic idle();
    l_drv(1, 1, 1, 0, 0);
    r_drv(1, 1, 1, 0, 0);
    l_busy_n = 1'b1;
    r_busy_n = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int prev, expv, ld, rd;
    idle();
    cyc(); cyc(); cyc();
    // R1 reset values
    chk("R1 l_int_n", l_int_n, 1);
    chk("R1 r_int_n", r_int_n, 1);
    chk("R1 l_rdata", l_rdata, 0);
    chk("R1 r_rdata", r_rdata, 0);
    rst = 1'b0;
    cyc();
    chk("R1 l_int_n after release", l_int_n, 1);

    // R2 R10: fill every address, evens from left, odds from right
    for (int a = 0; a <= TOPA; a += 2) begin
      l_drv(0, 1, 0, a, dat(a));
      r_drv(0, 1, 0, a + 1, dat(a + 1));
      cyc();
    end
    idle();
    cyc();
    // R11: own-mailbox writes raised nothing
    chk("R11 l_int_n after own write", l_int_n, 1);
    chk("R11 r_int_n after own write", r_int_n, 1);
    for (int a = 0; a <= TOPA; a++) begin
      l_drv(0, 0, 1, a, 0);
      r_drv(0, 0, 1, TOPA - a, 0);
      cyc();
      chk((a >= TOPA - 1) ? "R10 left mailbox data" : "R2 left read", l_rdata, dat(a));
      chk((TOPA - a >= TOPA - 1) ? "R10 right mailbox data" : "R2 right read",
          r_rdata, dat(TOPA - a));
    end
    // R12: hold with no read
    idle();
    cyc(); cyc();
    chk("R12 l_rdata hold", l_rdata, dat(TOPA));
    chk("R12 r_rdata hold", r_rdata, dat(0));
    l_drv(0, 1, 0, 3, 8'h5A);   // write, not a read
    cyc();
    idle();
    chk("R12 l_rdata hold on write", l_rdata, dat(TOPA));

    // R8: writes while busy are dropped
    l_drv(0, 1, 0, 7, ~dat(7)); l_busy_n = 1'b0;
    r_drv(0, 1, 0, 9, ~dat(9)); r_busy_n = 1'b0;
    cyc();
    idle();
    l_drv(0, 0, 1, 7, 0);
    r_drv(0, 0, 1, 9, 0);
    cyc();
    chk("R8 left busy write dropped", l_rdata, dat(7));
    chk("R8 right busy write dropped", r_rdata, dat(9));
    idle();

    // R3 R4 R7 R9: sweep on the left flag from both start levels
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 16; k++) begin
        idle();
        if (s == 1) begin r_drv(0, 1, 0, LM, 8'h11); l_drv(0, 1, 0, RM, 8'h22); end
        else        begin l_drv(0, 0, 1, LM, 0);     r_drv(0, 0, 1, RM, 0);     end
        cyc();
        prev = (s == 1) ? 0 : 1;
        chk("R3 R5 prep level left", l_int_n, prev);
        chk("R3 R5 prep level right", r_int_n, prev);
        idle();
        if (k[0]) r_drv(0, 1, 0, LM, k);
        if (k[1]) l_drv(0, 0, 1, LM, 0);
        r_busy_n = ~k[2];
        l_busy_n = ~k[3];
        cyc();
        expv = (k[0] && !k[2]) ? 0 : ((k[1] && !k[3]) ? 1 : prev);
        chk("R3 R4 R7 R9 left flag", l_int_n, expv);
        chk("R11 right flag untouched", r_int_n, prev);
      end
    end

    // R5 R6 R7 R9: same sweep mirrored onto the right flag
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 16; k++) begin
        idle();
        if (s == 1) begin r_drv(0, 1, 0, LM, 8'h11); l_drv(0, 1, 0, RM, 8'h22); end
        else        begin l_drv(0, 0, 1, LM, 0);     r_drv(0, 0, 1, RM, 0);     end
        cyc();
        prev = (s == 1) ? 0 : 1;
        idle();
        if (k[0]) l_drv(0, 1, 0, RM, k);
        if (k[1]) r_drv(0, 0, 1, RM, 0);
        l_busy_n = ~k[2];
        r_busy_n = ~k[3];
        cyc();
        expv = (k[0] && !k[2]) ? 0 : ((k[1] && !k[3]) ? 1 : prev);
        chk("R5 R6 R7 R9 right flag", r_int_n, expv);
        chk("R11 left flag untouched", l_int_n, prev);
      end
    end

    // R4: a write with output enable low still clears
    idle(); r_drv(0, 1, 0, LM, 1); cyc();
    idle(); l_drv(0, 0, 0, LM, 8'h77); cyc();
    chk("R4 clear with write strobe low", l_int_n, 1);
    // R6 with write strobe low
    idle(); l_drv(0, 1, 0, RM, 1); cyc();
    idle(); r_drv(0, 0, 0, RM, 8'h66); cyc();
    chk("R6 clear with write strobe low", r_int_n, 1);

    // R11: accesses that must not change a flag
    idle(); r_drv(0, 1, 0, LM, 8'h33); cyc();
    chk("R3 set before R11 probes", l_int_n, 0);
    idle(); l_drv(0, 1, 0, LM, 8'h44); cyc();
    chk("R11 own write oe high keeps flag", l_int_n, 0);
    idle(); r_drv(0, 0, 1, LM, 0); cyc();
    chk("R11 peer read keeps flag", l_int_n, 0);
    idle(); l_drv(1, 0, 1, LM, 0); cyc();
    chk("R11 disabled access keeps flag", l_int_n, 0);
    idle(); l_drv(0, 0, 1, LM - 1, 0); r_drv(0, 1, 0, LM - 1, 0); cyc();
    chk("R11 neighbour address keeps flag", l_int_n, 0);
    chk("R11 neighbour keeps right flag", r_int_n, 1);
    // R10: message bytes kept in the mailbox locations
    idle(); l_drv(0, 0, 1, LM, 0); r_drv(0, 0, 1, RM, 0); cyc();
    ld = l_rdata; rd = r_rdata;
    chk("R10 left mailbox message", ld, 8'h44);
    chk("R10 right mailbox message", rd, 8'h66);
    chk("R4 read clears left flag", l_int_n, 1);

    idle();
    cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule